// File: doc/BRIEF.md
# Rectangular Copy and Fill Engine

This engine moves bytes into a rectangular region of memory, one line at a time. A transfer is described by a line length in bytes, a separate line pitch for the source side and for the destination side, a byte total minus one, two start addresses, a 16-bit fill pattern and a control word. Each byte is either read from the source or made inside the engine (constant 0x00 or 0xFF, or the fill pattern). The bytes can be re-ordered in groups of 8 or 16 before they are written. Expanding a bit mask into fill values is handled by a separate block, so the mask-enable flag has no effect here unless it is overridden.

There are three byte streams, all with valid/ready handshakes. The read-request stream carries source addresses. The read-response stream returns one data byte per request, in request order. The write stream carries an address and a byte. A transfer moves only when valid and ready are both high at a clock edge. The engine keeps a request or a write, with its address and data unchanged, until it is accepted. It takes a response only when it can store it. Start, stop, busy and the done pulse are plain signals. The remaining count and the next source and destination addresses can be read live on output ports.

Control word fields used by the engine: bit 0 selects 16-byte group reversal; bit 1 selects 8-byte group reversal; bits 5:2 form the source code; bit 6 sets the fill width; bit 7 is the mask-enable flag; bit 10 selects pattern fill.

Top module: `dma_blit_engine`

## Requirements
- R1: Byte i of a transfer goes to destination address dst + (i / line)·dst_pitch + (i mod line), where line is the line length. In copy modes the source line starts advance by src_pitch in the same way.
- R2: `cnt_left` reads 0xFFFFFF after reset. It is loaded with the byte total minus one on start and drops by one for each accepted write. Exactly total-minus-one plus one writes occur, and it reads 0xFFFFFF when the transfer ends.
- R3: Source code 0x3 reads the source at falling addresses within each line. Code 0xC, and every code other than 0x0, 0x3 and 0xF, reads at rising addresses. Each read byte is written in read order.
- R4: Source code 0x0 writes 0x00 and code 0xF writes 0xFF to every destination byte, with no read requests.
- R5: When bit 10 is set, the engine writes the fill pattern to every byte and makes no reads. This holds whatever the source code and bit 7 are.
- R6: With bit 10 set and bit 6 at 0, every byte gets the pattern's low byte. With bit 6 at 1, byte n of the transfer gets the pattern's low byte when n is even and its high byte when n is odd.
- R7: Bit 1 reverses the byte order within each consecutive 8-byte group of the transfer. Bit 0 does the same for 16-byte groups and wins if both bits are set. The final partial group is reversed within itself. Destination addresses keep their ascending R1 order.
- R8: A start while idle raises `busy` at the next edge. `busy` stays high until completion or abort. A start while busy is ignored.
- R9: A stop while busy lowers `busy` at the next edge. After that edge there are no further writes and no done pulse. A write accepted in the stop cycle itself still counts.
- R10: `done_irq` is high for exactly one cycle: the cycle after the final write is accepted. If that write and a stop fall on the same edge, completion wins and the pulse is still raised.
- R11: `cur_src` and `cur_dst` show the next read and write addresses. After completion they equal the R1/R3 address of byte index total. In fill modes `cur_src` stays at the start source address.
- R12: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold at the next edge unless a stop is applied. Read requests hold in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ctrl | input | 11 | Control word, sampled on start |
| cfg_line | input | 16 | Bytes per line, at least 1 |
| cfg_src_pitch | input | 32 | Source line-start step |
| cfg_dst_pitch | input | 32 | Destination line-start step |
| cfg_total_m1 | input | 24 | Byte total minus one |
| cfg_src_addr | input | 32 | First source address |
| cfg_dst_addr | input | 32 | First destination address |
| cfg_pattern | input | 16 | Fill pattern |
| start | input | 1 | Begin a transfer |
| stop | input | 1 | Abort the running transfer |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| cnt_left | output | 24 | Live remaining count minus one |
| cur_src | output | 32 | Next source address |
| cur_dst | output | 32 | Next destination address |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine takes read data |
| rd_rsp_data | input | 8 | Read data byte |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write address |
| wr_data | output | 8 | Write data byte |

## Verification
The final write of a transfer and an abort can land on the same clock edge. The bench sets this up in three steps. It lets all but the last write through, then holds `wr_ready` low while the last byte waits. In one cycle it then raises `stop` and releases `wr_ready`. The result passes only if that byte is written at its expected address, the count reads 0xFFFFFF and `done_irq` still pulses once. A separate abort in mid-transfer, with writes blocked, must give no later writes and no pulse.

// File: rtl/dma_blit_pkg.sv
package dma_blit_pkg;

  localparam int CTL_W      = 11;
  localparam int CTL_REV16  = 0;
  localparam int CTL_REV8   = 1;
  localparam int CTL_SRC_LO = 2;
  localparam int CTL_WIDE   = 6;
  localparam int CTL_MASKED = 7;
  localparam int CTL_PATFIL = 10;

  typedef enum logic [1:0] {
    SRC_UP,
    SRC_DOWN,
    SRC_ZERO,
    SRC_ONES
  } src_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_REQ,
    PH_RSP,
    PH_GEN
  } prod_phase_e;

  function automatic src_mode_e decode_src(input logic [3:0] code);
    case (code)
      4'h3:    return SRC_DOWN;
      4'h0:    return SRC_ZERO;
      4'hF:    return SRC_ONES;
      default: return SRC_UP;
    endcase
  endfunction

endpackage

// File: rtl/dma_line_addr.sv
module dma_line_addr #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pitch,
  input  logic [LW-1:0] line_len,
  input  logic          down,
  input  logic          step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] row_start;
  logic [AW-1:0] cur;
  logic [LW-1:0] col;
  logic          row_end;

  assign row_end = (col == line_len - LW'(1));
  assign addr    = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_start <= '0;
      cur       <= '0;
      col       <= '0;
    end else if (load) begin
      row_start <= base;
      cur       <= base;
      col       <= '0;
    end else if (step) begin
      if (row_end) begin
        row_start <= row_start + pitch;
        cur       <= row_start + pitch;
        col       <= '0;
      end else begin
        cur <= down ? cur - AW'(1) : cur + AW'(1);
        col <= col + LW'(1);
      end
    end
  end

  // R1: within a line the address moves by one per step
  property p_col_step_r1;
    @(posedge clk) disable iff (!rst_n)
      step && !load && !row_end && !down |=> addr == $past(addr) + AW'(1);
  endproperty
  a_col_step_r1: assert property (p_col_step_r1);

  // R3: descending lines count down
  property p_col_down_r3;
    @(posedge clk) disable iff (!rst_n)
      step && !load && !row_end && down |=> addr == $past(addr) - AW'(1);
  endproperty
  a_col_down_r3: assert property (p_col_down_r3);

  // R1: the last byte of a line leads to column zero of the next
  property p_row_wrap_r1;
    @(posedge clk) disable iff (!rst_n)
      step && !load && row_end |=> col == '0;
  endproperty
  a_row_wrap_r1: assert property (p_row_wrap_r1);

endmodule

// File: rtl/dma_group_rev.sv
module dma_group_rev #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic [$clog2(DEPTH):0]     grp_len,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_data,
  input  logic                       in_last,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_data
);

  localparam int AIW = $clog2(DEPTH);
  localparam int GIW = AIW + 1;

  logic [7:0]     slot [DEPTH];
  logic [AIW-1:0] fill_cnt;
  logic [AIW-1:0] rd_idx;
  logic           draining;
  logic           grp_full;

  assign in_ready  = !draining && !clear;
  assign out_valid = draining;
  assign out_data  = slot[rd_idx];
  assign grp_full  = ({1'b0, fill_cnt} + GIW'(1)) == grp_len;

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) slot[fill_cnt] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      rd_idx   <= '0;
      draining <= 1'b0;
    end else if (clear) begin
      fill_cnt <= '0;
      rd_idx   <= '0;
      draining <= 1'b0;
    end else if (draining) begin
      if (out_ready) begin
        if (rd_idx == '0) draining <= 1'b0;
        else              rd_idx   <= rd_idx - AIW'(1);
      end
    end else if (in_valid) begin
      if (grp_full || in_last) begin
        draining <= 1'b1;
        rd_idx   <= fill_cnt;
        fill_cnt <= '0;
      end else begin
        fill_cnt <= fill_cnt + AIW'(1);
      end
    end
  end

  // R7: a group never collects more bytes than its length
  property p_no_overflow_r7;
    @(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |-> ({1'b0, fill_cnt} < grp_len);
  endproperty
  a_no_overflow_r7: assert property (p_no_overflow_r7);

  // R12: an offered byte stays put until taken
  property p_out_hold_r12;
    @(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !clear |=> out_valid && $stable(out_data);
  endproperty
  a_out_hold_r12: assert property (p_out_hold_r12);

endmodule

// File: rtl/dma_blit_engine.sv
module dma_blit_engine
  import dma_blit_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 24,
  parameter int LW  = 16,
  parameter int GRP = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CTL_W-1:0]    cfg_ctrl,
  input  logic [LW-1:0]       cfg_line,
  input  logic [AW-1:0]       cfg_src_pitch,
  input  logic [AW-1:0]       cfg_dst_pitch,
  input  logic [CW-1:0]       cfg_total_m1,
  input  logic [AW-1:0]       cfg_src_addr,
  input  logic [AW-1:0]       cfg_dst_addr,
  input  logic [15:0]         cfg_pattern,
  input  logic                start,
  input  logic                stop,
  output logic                busy,
  output logic                done_irq,
  output logic [CW-1:0]       cnt_left,
  output logic [AW-1:0]       cur_src,
  output logic [AW-1:0]       cur_dst,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [AW-1:0]       rd_req_addr,
  input  logic                rd_rsp_valid,
  output logic                rd_rsp_ready,
  input  logic [7:0]          rd_rsp_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [AW-1:0]       wr_addr,
  output logic [7:0]          wr_data
);

  localparam int GIW = $clog2(GRP) + 1;

  // latched job settings
  logic [LW-1:0]  line_q;
  logic [AW-1:0]  spitch_q, dpitch_q;
  logic [15:0]    pat_q;
  src_mode_e      smode_q;
  logic           patfill_q, wide_q, copy_q;
  logic [GIW-1:0] glen_q;

  // run state
  prod_phase_e    ph;
  logic [CW-1:0]  prod_left;
  logic           odd_q;
  logic           busy_q, irq_q;
  logic [CW-1:0]  cnt_q;

  logic           start_go, stop_go, wr_hs, rd_hs, final_wr;
  src_mode_e      smode_d;
  logic           copy_d;
  logic [GIW-1:0] glen_d;
  logic [7:0]     made_byte;

  logic           bi_valid, bi_ready, bi_last, bi_hs;
  logic [7:0]     bi_data, bo_data;
  logic           bo_valid;

  assign start_go = start && !busy_q;
  assign stop_go  = stop && busy_q;
  assign wr_hs    = wr_valid && wr_ready;
  assign rd_hs    = rd_req_valid && rd_req_ready;
  assign final_wr = busy_q && wr_hs && (cnt_q == '0);

  assign smode_d = decode_src(cfg_ctrl[CTL_SRC_LO +: 4]);
  assign copy_d  = !cfg_ctrl[CTL_PATFIL] && (smode_d == SRC_UP || smode_d == SRC_DOWN);
  assign glen_d  = cfg_ctrl[CTL_REV16] ? GIW'(GRP) :
                   cfg_ctrl[CTL_REV8]  ? GIW'(GRP / 2) : GIW'(1);

  always_comb begin
    if (patfill_q)                made_byte = (wide_q && odd_q) ? pat_q[15:8] : pat_q[7:0];
    else if (smode_q == SRC_ONES) made_byte = 8'hFF;
    else                          made_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      spitch_q  <= '0;
      dpitch_q  <= '0;
      pat_q     <= '0;
      smode_q   <= SRC_UP;
      patfill_q <= 1'b0;
      wide_q    <= 1'b0;
      copy_q    <= 1'b0;
      glen_q    <= GIW'(1);
    end else if (start_go) begin
      line_q    <= cfg_line;
      spitch_q  <= cfg_src_pitch;
      dpitch_q  <= cfg_dst_pitch;
      pat_q     <= cfg_pattern;
      smode_q   <= smode_d;
      patfill_q <= cfg_ctrl[CTL_PATFIL];
      wide_q    <= cfg_ctrl[CTL_WIDE];
      copy_q    <= copy_d;
      glen_q    <= glen_d;
    end
  end

  // byte producer: reads or makes one byte at a time
  assign bi_hs = bi_valid && bi_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      prod_left <= '0;
      odd_q     <= 1'b0;
    end else if (start_go) begin
      ph        <= copy_d ? PH_REQ : PH_GEN;
      prod_left <= cfg_total_m1;
      odd_q     <= 1'b0;
    end else if (stop_go) begin
      ph <= PH_IDLE;
    end else begin
      case (ph)
        PH_REQ: if (rd_req_ready) ph <= PH_RSP;
        PH_RSP, PH_GEN: begin
          if (bi_hs) begin
            odd_q <= ~odd_q;
            if (prod_left == '0) begin
              ph <= PH_IDLE;
            end else begin
              prod_left <= prod_left - CW'(1);
              ph        <= copy_q ? PH_REQ : PH_GEN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_req_valid = busy_q && (ph == PH_REQ);
  assign rd_req_addr  = cur_src;
  assign rd_rsp_ready = (ph == PH_RSP) ? bi_ready : !busy_q;
  assign bi_valid     = (ph == PH_GEN) || (ph == PH_RSP && rd_rsp_valid);
  assign bi_data      = (ph == PH_RSP) ? rd_rsp_data : made_byte;
  assign bi_last      = (prod_left == '0);

  dma_line_addr #(.AW(AW), .LW(LW)) u_src_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_go),
    .base     (cfg_src_addr),
    .pitch    (spitch_q),
    .line_len (line_q),
    .down     (smode_q == SRC_DOWN),
    .step     (rd_hs),
    .addr     (cur_src)
  );

  dma_line_addr #(.AW(AW), .LW(LW)) u_dst_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_go),
    .base     (cfg_dst_addr),
    .pitch    (dpitch_q),
    .line_len (line_q),
    .down     (1'b0),
    .step     (busy_q && wr_hs),
    .addr     (cur_dst)
  );

  dma_group_rev #(.DEPTH(GRP)) u_group_rev (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (stop_go),
    .grp_len   (glen_q),
    .in_valid  (bi_valid),
    .in_ready  (bi_ready),
    .in_data   (bi_data),
    .in_last   (bi_last),
    .out_valid (bo_valid),
    .out_ready (wr_ready),
    .out_data  (bo_data)
  );

  assign wr_valid = bo_valid;
  assign wr_addr  = cur_dst;
  assign wr_data  = bo_data;

  // job state: busy, count, done pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '1;
    end else begin
      irq_q <= final_wr;
      if (start_go) begin
        busy_q <= 1'b1;
        cnt_q  <= cfg_total_m1;
      end else begin
        if (busy_q && wr_hs) cnt_q <= cnt_q - CW'(1);
        if (final_wr || stop_go) busy_q <= 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign done_irq = irq_q;
  assign cnt_left = cnt_q;

  // R10: the done pulse lasts one cycle
  property p_irq_single_r10;
    @(posedge clk) disable iff (!rst_n) done_irq |=> !done_irq;
  endproperty
  a_irq_single_r10: assert property (p_irq_single_r10);

  // R10: the pulse follows a busy cycle and finds the engine idle
  property p_irq_after_busy_r10;
    @(posedge clk) disable iff (!rst_n) done_irq |-> !busy && $past(busy);
  endproperty
  a_irq_after_busy_r10: assert property (p_irq_after_busy_r10);

  // R2: the count is spent when the pulse appears
  property p_cnt_spent_r2;
    @(posedge clk) disable iff (!rst_n) done_irq |-> cnt_left == '1;
  endproperty
  a_cnt_spent_r2: assert property (p_cnt_spent_r2);

  // R4: fill jobs never request reads
  property p_no_read_fill_r4;
    @(posedge clk) disable iff (!rst_n) busy && !copy_q |-> !rd_req_valid;
  endproperty
  a_no_read_fill_r4: assert property (p_no_read_fill_r4);

  // R9: stop ends the job at the next edge
  property p_stop_idle_r9;
    @(posedge clk) disable iff (!rst_n) stop && busy |=> !busy;
  endproperty
  a_stop_idle_r9: assert property (p_stop_idle_r9);

  // R12: a waiting write keeps address and data
  property p_wr_hold_r12;
    @(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready && !stop |=> wr_valid && $stable(wr_addr) && $stable(wr_data);
  endproperty
  a_wr_hold_r12: assert property (p_wr_hold_r12);

  // R12: a waiting read request keeps its address
  property p_rd_hold_r12;
    @(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready && !stop |=> rd_req_valid && $stable(rd_req_addr);
  endproperty
  a_rd_hold_r12: assert property (p_rd_hold_r12);

endmodule

// File: tb/test_dma_blit_engine.sv
module test_dma_blit_engine;
  localparam int AW = 32;
  localparam int CW = 24;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [10:0]   cfg_ctrl;
  logic [LW-1:0] cfg_line;
  logic [AW-1:0] cfg_src_pitch, cfg_dst_pitch, cfg_src_addr, cfg_dst_addr;
  logic [CW-1:0] cfg_total_m1;
  logic [15:0]   cfg_pattern;
  logic          start, stop, busy, done_irq;
  logic [CW-1:0] cnt_left;
  logic [AW-1:0] cur_src, cur_dst, rd_req_addr, wr_addr;
  logic          rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [7:0]    rd_rsp_data, wr_data;
  logic          wr_valid, wr_ready;

  dma_blit_engine i_dma_blit_engine (
    .clk, .rst_n, .cfg_ctrl, .cfg_line, .cfg_src_pitch, .cfg_dst_pitch,
    .cfg_total_m1, .cfg_src_addr, .cfg_dst_addr, .cfg_pattern,
    .start, .stop, .busy, .done_irq, .cnt_left, .cur_src, .cur_dst,
    .rd_req_valid, .rd_req_ready, .rd_req_addr,
    .rd_rsp_valid, .rd_rsp_ready, .rd_rsp_data,
    .wr_valid, .wr_ready, .wr_addr, .wr_data
  );

  int n_tests = 0, n_fail = 0;
  logic [AW-1:0] exp_wa[$];
  logic [7:0]    exp_wd[$];
  logic [AW-1:0] exp_ra[$];
  logic [AW-1:0] pend[$];
  bit            rsp_taken = 0;
  int            wr_mode = 0;
  int            n_rd = 0, n_wr = 0, n_irq = 0;
  logic [15:0]   lfsr = 16'hACE1;
  string         tag = "R1";
  logic          pw_wait = 0;
  logic [AW-1:0] pw_addr;
  logic [7:0]    pw_data;
  logic          pw_stop;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] src_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // memory model and scoreboard monitor
  always begin
    @(negedge clk);
    if (rsp_taken) begin pend.delete(0); rsp_taken = 0; end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_rsp_valid = (pend.size() > 0) && lfsr[1];
    rd_rsp_data  = (pend.size() > 0) ? src_byte(pend[0]) : 8'h00;
    rd_req_ready = lfsr[2] | lfsr[5];
    wr_ready     = (wr_mode == 1) ? 1'b0 : (wr_mode == 2) ? 1'b1 : (lfsr[3] | lfsr[7]);
    #1;
    if (pw_wait && !pw_stop && rst_n) begin
      check(wr_valid && wr_addr == pw_addr && wr_data == pw_data, "R12",
            "held write", {wr_addr, wr_data}, {pw_addr, pw_data});
    end
    pw_wait = wr_valid && !wr_ready;
    pw_addr = wr_addr;
    pw_data = wr_data;
    pw_stop = stop;
    if (rd_req_valid && rd_req_ready) begin
      n_rd++;
      if (exp_ra.size() == 0) check(0, tag, "unexpected read", rd_req_addr, 0);
      else begin
        check(rd_req_addr == exp_ra[0], tag, "read address", rd_req_addr, exp_ra[0]);
        exp_ra.delete(0);
      end
      pend.push_back(rd_req_addr);
    end
    if (rd_rsp_valid && rd_rsp_ready) rsp_taken = 1;
    if (wr_valid && wr_ready) begin
      n_wr++;
      if (exp_wa.size() == 0) check(0, tag, "unexpected write", wr_addr, 0);
      else begin
        check(wr_addr == exp_wa[0] && wr_data == exp_wd[0], tag, "write addr/data",
              {wr_addr, wr_data}, {exp_wa[0], exp_wd[0]});
        exp_wa.delete(0);
        exp_wd.delete(0);
      end
    end
    if (done_irq) n_irq++;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // driver: computes the expected streams, then starts the job
  task automatic run_job(input string t, input logic [10:0] ctrl, input int line,
                         input int sp, input int dp, input int m1,
                         input logic [AW-1:0] sa, input logic [AW-1:0] da,
                         input logic [15:0] pat, input bit wait_done, input int restart_at);
    logic [7:0]    dv[$];
    logic [AW-1:0] dav[$];
    logic [3:0]    sc;
    bit            copy;
    int            glen, n, irq0, rd0, guard;
    logic [AW-1:0] end_src, end_dst;
    n    = m1 + 1;
    sc   = ctrl[5:2];
    copy = !ctrl[10] && sc != 4'h0 && sc != 4'hF;
    glen = ctrl[0] ? 16 : ctrl[1] ? 8 : 1;
    for (int i = 0; i <= n; i++) begin
      logic [AW-1:0] s, d;
      int ln, off;
      ln  = i / line;
      off = i % line;
      d   = da + AW'(ln * dp) + AW'(off);
      s   = (sc == 4'h3) ? sa + AW'(ln * sp) - AW'(off) : sa + AW'(ln * sp) + AW'(off);
      if (i == n) begin
        end_dst = d;
        end_src = copy ? s : sa;
      end else begin
        dav.push_back(d);
        if (ctrl[10])         dv.push_back((ctrl[6] && (i % 2 == 1)) ? pat[15:8] : pat[7:0]);
        else if (sc == 4'h0)  dv.push_back(8'h00);
        else if (sc == 4'hF)  dv.push_back(8'hFF);
        else begin
          exp_ra.push_back(s);
          dv.push_back(src_byte(s));
        end
      end
    end
    for (int g = 0; g < n; g += glen) begin
      int len;
      len = (n - g < glen) ? n - g : glen;
      for (int j = 0; j < len; j++) begin
        exp_wa.push_back(dav[g + j]);
        exp_wd.push_back(dv[g + len - 1 - j]);
      end
    end
    tag = t;
    irq0 = n_irq;
    rd0  = n_rd;
    cfg_ctrl = ctrl; cfg_line = LW'(line); cfg_src_pitch = AW'(sp); cfg_dst_pitch = AW'(dp);
    cfg_total_m1 = CW'(m1); cfg_src_addr = sa; cfg_dst_addr = da; cfg_pattern = pat;
    start = 1'b1;
    tick();
    start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
    check(cnt_left == CW'(m1), "R2", "count loaded", cnt_left, m1);
    if (!wait_done) return;
    guard = 0;
    while (busy && guard < 20000) begin
      if (restart_at != 0 && guard == restart_at) begin
        start = 1'b1; tick(); start = 1'b0;
      end else tick();
      guard++;
    end
    check(guard < 20000, t, "job finished", guard, 0);
    check(done_irq == 1'b1, "R10", "pulse with busy fall", done_irq, 1);
    check(cnt_left == '1, "R2", "count spent", cnt_left, 24'hFFFFFF);
    check(cur_dst == end_dst, "R11", "final dst address", cur_dst, end_dst);
    check(cur_src == end_src, "R11", "final src address", cur_src, end_src);
    tick();
    check(done_irq == 1'b0, "R10", "pulse one cycle", done_irq, 0);
    tick(); tick();
    check(busy == 1'b0, "R8", "stays idle", busy, 0);
    check(n_irq == irq0 + 1, "R10", "pulse count", n_irq, irq0 + 1);
    check(exp_wa.size() == 0, "R2", "writes outstanding", exp_wa.size(), 0);
    check(exp_ra.size() == 0, t, "reads outstanding", exp_ra.size(), 0);
    if (!copy) check(n_rd == rd0, t, "no reads in fill", n_rd - rd0, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w0, i0, guard;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0;
    cfg_ctrl = '0; cfg_line = 16'd1; cfg_src_pitch = '0; cfg_dst_pitch = '0;
    cfg_total_m1 = '0; cfg_src_addr = '0; cfg_dst_addr = '0; cfg_pattern = '0;
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = 0; wr_ready = 0;
    repeat (4) tick();
    check(busy == 0 && done_irq == 0 && wr_valid == 0 && rd_req_valid == 0, "R8",
          "reset outputs", {busy, done_irq, wr_valid, rd_req_valid}, 0);
    check(cnt_left == '1, "R2", "reset count", cnt_left, 24'hFFFFFF);
    rst_n = 1'b1;
    tick();

    run_job("R1", 11'h030, 5, 16, 32, 19, 32'h1000, 32'h8000, 16'h0, 1, 0);
    run_job("R3", 11'h00C, 4, 8, 12, 11, 32'h2043, 32'h9000, 16'h0, 1, 0);
    run_job("R4", 11'h000, 3, 0, 10, 8, 32'h0, 32'hA000, 16'h0, 1, 0);
    run_job("R4", 11'h03C, 3, 0, 10, 8, 32'h0, 32'hA100, 16'h0, 1, 0);
    run_job("R5", 11'h4B0, 6, 4, 8, 11, 32'h4000, 32'hB000, 16'hA55A, 1, 0);
    run_job("R6", 11'h440, 4, 0, 9, 9, 32'h0, 32'hB100, 16'hA55A, 1, 0);
    run_job("R7", 11'h032, 16, 16, 64, 31, 32'h3000, 32'hC000, 16'h0, 1, 0);
    run_job("R7", 11'h015, 16, 32, 16, 37, 32'h3100, 32'hC400, 16'h0, 1, 0);
    run_job("R3", 11'h013, 16, 32, 16, 20, 32'h3300, 32'hC800, 16'h0, 1, 0);
    run_job("R8", 11'h030, 8, 8, 8, 15, 32'h5000, 32'hD000, 16'h0, 1, 3);

    // R9: abort mid-transfer with writes blocked
    wr_mode = 1;
    run_job("R9", 11'h030, 4, 4, 4, 15, 32'h6000, 32'hE000, 16'h0, 0, 0);
    repeat (10) tick();
    check(wr_valid == 1'b1, "R9", "write waiting", wr_valid, 1);
    w0 = n_wr; i0 = n_irq;
    stop = 1'b1; tick(); stop = 1'b0;
    check(busy == 1'b0, "R9", "busy after stop", busy, 0);
    exp_wa.delete(); exp_wd.delete(); exp_ra.delete();
    wr_mode = 2;
    repeat (20) tick();
    check(n_wr == w0, "R9", "writes after stop", n_wr - w0, 0);
    check(n_irq == i0, "R9", "pulse after stop", n_irq - i0, 0);
    check(wr_valid == 1'b0, "R9", "write offered after stop", wr_valid, 0);
    wr_mode = 0;

    // R10: stop on the same edge as the final write
    wr_mode = 2;
    i0 = n_irq;
    run_job("R10", 11'h03C, 4, 0, 4, 3, 32'h0, 32'hF000, 16'h0, 0, 0);
    guard = 0;
    while (cnt_left != '0 && guard < 1000) begin tick(); guard++; end
    wr_mode = 1;
    tick(); tick();
    check(wr_valid == 1'b1 && busy == 1'b1, "R10", "last write pending", wr_valid, 1);
    stop = 1'b1; wr_mode = 2;
    tick();
    stop = 1'b0;
    check(busy == 1'b0, "R10", "idle after race", busy, 0);
    check(done_irq == 1'b1, "R10", "completion wins", done_irq, 1);
    check(cnt_left == '1, "R2", "count after race", cnt_left, 24'hFFFFFF);
    tick(); tick();
    check(n_irq == i0 + 1, "R10", "one pulse after race", n_irq - i0, 1);
    check(exp_wa.size() == 0, "R10", "final write done", exp_wa.size(), 0);
    wr_mode = 0;

    run_job("R1", 11'h030, 3, 7, 5, 13, 32'h7000, 32'hF800, 16'h0, 1, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule